// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Selectable Write Policy

This block is a direct-mapped data cache that sits between a core-side load/store port and a port to the next level of memory. Lines are aligned blocks of `LINE_BYTES` bytes (32, 64 or 128). A load that misses brings in the whole aligned line, one 32-bit word per beat, before it answers the core. The parameter `WRITE_BACK` selects the store policy. With write-through (`WRITE_BACK=0`), every store goes to memory as a single write beat, and there is no allocation on a store miss. On a store hit, `WT_UPDATE` decides whether the cached copy is patched or dropped. With write-back (`WRITE_BACK=1`), stores stay in the cache and mark their line dirty, and a store miss allocates the line first. A dirty line is written back in full before a refill may reuse its slot.

A flush request walks every line index from 0 upward and writes back each dirty line it finds. After the last index it pulses `flush_done`. From that point every valid line equals memory. The core handles one request at a time, and each request finishes before the next one is accepted.

Back-pressure rules:
- **Core request port.** A request transfers on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle and `flush_go` is low.
- **Core response.** `rsp_valid` is a one-cycle pulse that cannot be stalled. It comes for loads and stores, and for loads `rsp_rdata` holds the word.
- **Memory port.** The cache holds `mem_valid`, `mem_we`, `mem_addr`, `mem_wdata` and `mem_be` steady until `mem_ready` is seen. On a read beat, `mem_rdata` must be valid in the same cycle as the handshake.

Top module: `dcache_wp`

## Requirements
- R1: After reset every line is invalid and not dirty. `req_ready` is high, while `rsp_valid`, `mem_valid` and `flush_done` are low. The first load to any address therefore misses.
- R2: On a load miss, the cache issues `LINE_BYTES/4` read beats. Their byte addresses run from the line base upward in steps of 4. The cache then pulses `rsp_valid` with the addressed word. No response appears while a refill is part-way through.
- R3: A load hit answers with the cached word and makes no memory beats.
- R4: In write-through mode, each store makes exactly one write beat, carrying the store's address, data and byte enables. `rsp_valid` pulses in that beat's handshake cycle. A store miss does not allocate a line.
- R5: In write-through mode, a store hit with `WT_UPDATE=1` patches the cached word under the byte enables. With `WT_UPDATE=0` the line is made invalid, so the next load to it refills.
- R6: In write-back mode, a store hit merges the data into the cached word under the byte enables (bit i covers byte i, bits 8i+7..8i) and makes no memory beats.
- R7: In write-back mode, a store miss refills the line, then merges the store data and marks the line dirty.
- R8: Replacing a dirty line first writes all of its words to memory, at the old tag's addresses in ascending order. Only after that does any refill read start.
- R9: After a write-back the line stays valid and clean. A later load to it hits, and a second flush writes nothing.
- R10: A flush writes back dirty lines only, in ascending index order. `flush_done` is a one-cycle pulse after the last index. In write-through mode a flush makes no beats.
- R11: When `flush_done` pulses, every valid line equals memory at its address.
- R12: The core port has one request in flight at a time. `req_ready` is low while `flush_go` is high. The memory request stays stable while it is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Core request accepted when high with req_valid |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address (low two bits ignored) |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte enables |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Load data, valid with rsp_valid |
| mem_valid | output | 1 | Memory beat request |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | ADDR_W | Word-aligned byte address of the beat |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte enables |
| mem_rdata | input | 32 | Read data, valid in the handshake cycle |
| flush_go | input | 1 | Start a flush, taken while idle |
| flush_done | output | 1 | One-cycle pulse when the flush has finished |

## Verification
The checks take two things from the environment:
- memory delivers read data in the cycle of the read handshake;
- the core raises `flush_go` only while idle, and accepts every response pulse at once.

On that basis they require:
- no response during a partial refill;
- no read beat while a line write-back is incomplete;
- a stalled memory request that stays unchanged;
- a write-through write beat that coincides with its response.

The bench respects those assumptions:
- its memory model returns `mem_rdata` combinationally from the beat address;
- it varies `mem_ready` with a cycle pattern that differs per instance;
- it raises `flush_go` only when `req_ready` shows the controller idle;
- it runs one write-back instance and two write-through instances side by side.

// File: rtl/dc_pkg.sv
package dc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WRITEBACK,
    ST_REFILL,
    ST_FLUSH
  } dc_state_e;

  localparam int WORD_BYTES = 4;

endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
  parameter int LINES = 8,
  parameter int IDX_W = 3,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  output logic             line_valid,
  output logic             line_dirty,
  output logic [TAG_W-1:0] line_tag,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             dirty_set,
  input  logic             dirty_clr,
  input  logic             inval
);

  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  assign line_valid = valid_q[idx];
  assign line_dirty = dirty_q[idx];
  assign line_tag   = tag_q[idx];

  // status bits: reset clears every line
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (fill_en) begin
        valid_q[idx] <= 1'b1;
        dirty_q[idx] <= 1'b0;
      end
      if (dirty_set) dirty_q[idx] <= 1'b1;
      if (dirty_clr) dirty_q[idx] <= 1'b0;
      if (inval)     valid_q[idx] <= 1'b0;
    end
  end

  // tags need no reset: they are qualified by valid
  always_ff @(posedge clk) begin
    if (fill_en) tag_q[idx] <= fill_tag;
  end

endmodule

// File: rtl/dc_data_store.sv
module dc_data_store #(
  parameter int LINES  = 8,
  parameter int IDX_W  = 3,
  parameter int WSEL_W = 3
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WSEL_W-1:0] rd_word,
  output logic [31:0]       rd_data,
  input  logic              wr_en,
  input  logic [WSEL_W-1:0] wr_word,
  input  logic [31:0]       wr_data,
  input  logic [3:0]        wr_be
);

  localparam int WPL   = 1 << WSEL_W;
  localparam int DEPTH = LINES * WPL;
  localparam int AW    = IDX_W + WSEL_W;

  logic [31:0] arr [DEPTH];

  assign rd_data = arr[{idx, rd_word}];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < 4; b++) begin
        if (wr_be[b]) arr[AW'({idx, wr_word})][8*b +: 8] <= wr_data[8*b +: 8];
      end
    end
  end

endmodule

// File: rtl/dc_ctrl.sv
module dc_ctrl
  import dc_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int LINES      = 8,
  parameter int IDX_W      = 3,
  parameter int TAG_W      = 4,
  parameter int WSEL_W     = 3,
  parameter int WRITE_BACK = 1,
  parameter int WT_UPDATE  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  // core side
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [3:0]        req_be,
  output logic              rsp_valid,
  input  logic              flush_go,
  output logic              flush_done,
  // memory side
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  input  logic [31:0]       mem_rdata,
  // tag store
  output logic [IDX_W-1:0]  idx,
  input  logic              line_valid,
  input  logic              line_dirty,
  input  logic [TAG_W-1:0]  line_tag,
  output logic              fill_en,
  output logic [TAG_W-1:0]  fill_tag,
  output logic              dirty_set,
  output logic              dirty_clr,
  output logic              inval,
  // data store
  output logic [WSEL_W-1:0] rd_word,
  input  logic [31:0]       rd_data,
  output logic              wr_en,
  output logic [WSEL_W-1:0] wr_word,
  output logic [31:0]       wr_data,
  output logic [3:0]        wr_be
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);
  localparam int               OFF_W    = WSEL_W + 2;

  dc_state_e         state_q, state_d;
  logic [IDX_W-1:0]  idx_q;
  logic [TAG_W-1:0]  tag_q;
  logic [WSEL_W-1:0] word_q;
  logic [WSEL_W-1:0] beat_q;
  logic              we_q;
  logic [31:0]       wdata_q;
  logic [3:0]        be_q;
  logic              flushing_q;

  logic hit;
  logic victim_dirty;
  logic beat_last;
  logic accept;
  logic beat_fire;

  assign idx          = idx_q;
  assign fill_tag     = tag_q;
  assign hit          = line_valid && (line_tag == tag_q);
  assign victim_dirty = (WRITE_BACK != 0) && line_valid && line_dirty;
  assign beat_last    = &beat_q;
  assign accept       = (state_q == ST_IDLE) && !flush_go && req_valid;
  assign beat_fire    = mem_valid && mem_ready &&
                        ((state_q == ST_WRITEBACK) || (state_q == ST_REFILL));

  always_comb begin
    state_d    = state_q;
    req_ready  = 1'b0;
    rsp_valid  = 1'b0;
    flush_done = 1'b0;
    mem_valid  = 1'b0;
    mem_we     = 1'b0;
    mem_be     = 4'hF;
    mem_addr   = '0;
    mem_wdata  = wdata_q;
    fill_en    = 1'b0;
    dirty_set  = 1'b0;
    dirty_clr  = 1'b0;
    inval      = 1'b0;
    wr_en      = 1'b0;
    wr_word    = word_q;
    wr_data    = wdata_q;
    wr_be      = be_q;
    rd_word    = word_q;
    unique case (state_q)
      ST_IDLE: begin
        req_ready = !flush_go;
        if (flush_go)       state_d = ST_FLUSH;
        else if (req_valid) state_d = ST_LOOKUP;
      end
      ST_LOOKUP: begin
        if (we_q && (WRITE_BACK == 0)) begin
          // store goes straight to memory as one beat
          mem_valid = 1'b1;
          mem_we    = 1'b1;
          mem_be    = be_q;
          mem_addr  = {tag_q, idx_q, word_q, 2'b00};
          if (mem_ready) begin
            rsp_valid = 1'b1;
            state_d   = ST_IDLE;
            if (hit) begin
              if (WT_UPDATE != 0) wr_en = 1'b1;
              else                inval = 1'b1;
            end
          end
        end else if (hit) begin
          rsp_valid = 1'b1;
          state_d   = ST_IDLE;
          if (we_q) begin
            wr_en     = 1'b1;
            dirty_set = 1'b1;
          end
        end else begin
          state_d = victim_dirty ? ST_WRITEBACK : ST_REFILL;
        end
      end
      ST_WRITEBACK: begin
        rd_word   = beat_q;
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {line_tag, idx_q, beat_q, 2'b00};
        mem_wdata = rd_data;
        if (mem_ready && beat_last) begin
          dirty_clr = 1'b1;
          state_d   = flushing_q ? ST_FLUSH : ST_REFILL;
        end
      end
      ST_REFILL: begin
        mem_valid = 1'b1;
        mem_addr  = {tag_q, idx_q, beat_q, 2'b00};
        if (mem_ready) begin
          wr_en   = 1'b1;
          wr_word = beat_q;
          wr_data = mem_rdata;
          wr_be   = 4'hF;
          if (beat_last) begin
            fill_en = 1'b1;
            state_d = ST_LOOKUP;
          end
        end
      end
      ST_FLUSH: begin
        if (victim_dirty) begin
          state_d = ST_WRITEBACK;
        end else if (idx_q == LAST_IDX) begin
          flush_done = 1'b1;
          state_d    = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      tag_q      <= '0;
      word_q     <= '0;
      beat_q     <= '0;
      we_q       <= 1'b0;
      wdata_q    <= '0;
      be_q       <= '0;
      flushing_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (beat_fire) beat_q <= beat_q + 1'b1;
      if (state_q == ST_IDLE && flush_go) begin
        idx_q      <= '0;
        flushing_q <= 1'b1;
      end else if (accept) begin
        idx_q   <= req_addr[OFF_W +: IDX_W];
        tag_q   <= req_addr[ADDR_W-1 -: TAG_W];
        word_q  <= req_addr[2 +: WSEL_W];
        we_q    <= req_we;
        wdata_q <= req_wdata;
        be_q    <= req_be;
      end
      if (state_q == ST_FLUSH && !victim_dirty) begin
        if (idx_q == LAST_IDX) flushing_q <= 1'b0;
        else                   idx_q      <= idx_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/dcache_wp.sv
module dcache_wp #(
  parameter int ADDR_W     = 12,
  parameter int LINE_BYTES = 32,
  parameter int LINES      = 8,
  parameter int WRITE_BACK = 1,
  parameter int WT_UPDATE  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [3:0]        req_be,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  input  logic [31:0]       mem_rdata,
  input  logic              flush_go,
  output logic              flush_done
);

  localparam int WPL    = LINE_BYTES / dc_pkg::WORD_BYTES;
  localparam int WSEL_W = $clog2(WPL);
  localparam int OFF_W  = WSEL_W + 2;
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;

  logic [IDX_W-1:0]  idx;
  logic              line_valid, line_dirty;
  logic [TAG_W-1:0]  line_tag, fill_tag;
  logic              fill_en, dirty_set, dirty_clr, inval;
  logic [WSEL_W-1:0] rd_word, wr_word;
  logic [31:0]       rd_data, wr_data;
  logic              wr_en;
  logic [3:0]        wr_be;

  assign rsp_rdata = rd_data;

  dc_ctrl #(
    .ADDR_W(ADDR_W), .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W),
    .WSEL_W(WSEL_W), .WRITE_BACK(WRITE_BACK), .WT_UPDATE(WT_UPDATE)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .flush_go(flush_go), .flush_done(flush_done),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_rdata(mem_rdata),
    .idx(idx), .line_valid(line_valid), .line_dirty(line_dirty),
    .line_tag(line_tag), .fill_en(fill_en), .fill_tag(fill_tag),
    .dirty_set(dirty_set), .dirty_clr(dirty_clr), .inval(inval),
    .rd_word(rd_word), .rd_data(rd_data), .wr_en(wr_en),
    .wr_word(wr_word), .wr_data(wr_data), .wr_be(wr_be)
  );

  dc_tag_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .idx(idx),
    .line_valid(line_valid), .line_dirty(line_dirty), .line_tag(line_tag),
    .fill_en(fill_en), .fill_tag(fill_tag),
    .dirty_set(dirty_set), .dirty_clr(dirty_clr), .inval(inval)
  );

  dc_data_store #(.LINES(LINES), .IDX_W(IDX_W), .WSEL_W(WSEL_W)) u_data (
    .clk(clk), .idx(idx), .rd_word(rd_word), .rd_data(rd_data),
    .wr_en(wr_en), .wr_word(wr_word), .wr_data(wr_data), .wr_be(wr_be)
  );

endmodule

// File: rtl/dc_chk.sv
module dc_chk #(
  parameter int ADDR_W     = 12,
  parameter int LINE_BYTES = 32,
  parameter int WRITE_BACK = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              flush_done
);

  localparam int CW = $clog2(LINE_BYTES / 4);

  logic [CW-1:0] rd_cnt, wr_cnt;
  logic rd_fire, wr_fire;

  assign rd_fire = mem_valid && mem_ready && !mem_we;
  assign wr_fire = mem_valid && mem_ready && mem_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_cnt <= '0;
      wr_cnt <= '0;
    end else begin
      if (rd_fire) rd_cnt <= rd_cnt + 1'b1;
      if (wr_fire && WRITE_BACK != 0) wr_cnt <= wr_cnt + 1'b1;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !mem_valid && !rsp_valid && !flush_done);

  // R2
  no_rsp_mid_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rd_cnt == '0);

  // R8
  wb_before_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |-> wr_cnt == '0);

  // R4
  wt_beat_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (WRITE_BACK == 0) && wr_fire |-> rsp_valid);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |=> !flush_done);

  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_we) &&
                                $stable(mem_addr) && $stable(mem_wdata));

  // R12
  single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

endmodule

bind dcache_wp dc_chk #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .WRITE_BACK(WRITE_BACK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .flush_done(flush_done)
);

// File: tb/dcache_wp_tb.sv
module dcache_wp_tb;

  localparam int NDUT  = 3;   // 0: write-back, 1: write-through update, 2: write-through invalidate
  localparam int AW    = 12;
  localparam int WORDS = 1 << (AW - 2);
  localparam int LOGN  = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          req_valid [NDUT];
  logic          req_ready [NDUT];
  logic          req_we    [NDUT];
  logic [AW-1:0] req_addr  [NDUT];
  logic [31:0]   req_wdata [NDUT];
  logic [3:0]    req_be    [NDUT];
  logic          rsp_valid [NDUT];
  logic [31:0]   rsp_rdata [NDUT];
  logic          mem_valid [NDUT];
  logic          mem_ready [NDUT];
  logic          mem_we    [NDUT];
  logic [AW-1:0] mem_addr  [NDUT];
  logic [31:0]   mem_wdata [NDUT];
  logic [3:0]    mem_be    [NDUT];
  logic [31:0]   mem_rdata [NDUT];
  logic          flush_go  [NDUT];
  logic          flush_done[NDUT];

  logic [31:0]   mem     [NDUT][WORDS];
  int            rd_cnt  [NDUT];
  int            wr_cnt  [NDUT];
  int            log_cnt [NDUT];
  logic          log_we  [NDUT][LOGN];
  logic [AW-1:0] log_addr[NDUT][LOGN];
  int            cyc;

  int checks = 0;
  int failures = 0;

  for (genvar g = 0; g < NDUT; g++) begin : g_dut
    dcache_wp #(
      .ADDR_W(AW), .LINE_BYTES(32), .LINES(8),
      .WRITE_BACK(g == 0 ? 1 : 0), .WT_UPDATE(g == 1 ? 1 : 0)
    ) u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid[g]), .req_ready(req_ready[g]), .req_we(req_we[g]),
      .req_addr(req_addr[g]), .req_wdata(req_wdata[g]), .req_be(req_be[g]),
      .rsp_valid(rsp_valid[g]), .rsp_rdata(rsp_rdata[g]),
      .mem_valid(mem_valid[g]), .mem_ready(mem_ready[g]), .mem_we(mem_we[g]),
      .mem_addr(mem_addr[g]), .mem_wdata(mem_wdata[g]), .mem_be(mem_be[g]),
      .mem_rdata(mem_rdata[g]),
      .flush_go(flush_go[g]), .flush_done(flush_done[g])
    );
  end

  // memory model: combinational read, ready pattern differs per instance
  always_comb begin
    for (int g = 0; g < NDUT; g++) begin
      mem_rdata[g] = mem[g][mem_addr[g][AW-1:2]];
      mem_ready[g] = (cyc % (3 + g)) != 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      for (int g = 0; g < NDUT; g++) begin
        rd_cnt[g]  <= 0;
        wr_cnt[g]  <= 0;
        log_cnt[g] <= 0;
        for (int w = 0; w < WORDS; w++) mem[g][w] <= 32'h5A00_0000 | 32'(w);
      end
    end else begin
      for (int g = 0; g < NDUT; g++) begin
        if (mem_valid[g] && mem_ready[g]) begin
          log_we[g][log_cnt[g] % LOGN]   <= mem_we[g];
          log_addr[g][log_cnt[g] % LOGN] <= mem_addr[g];
          log_cnt[g] <= log_cnt[g] + 1;
          if (mem_we[g]) begin
            wr_cnt[g] <= wr_cnt[g] + 1;
            for (int b = 0; b < 4; b++)
              if (mem_be[g][b]) mem[g][mem_addr[g][AW-1:2]][8*b +: 8] <= mem_wdata[g][8*b +: 8];
          end else begin
            rd_cnt[g] <= rd_cnt[g] + 1;
          end
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic core_op(input int g, input bit we, input logic [AW-1:0] a,
                         input logic [31:0] d, input logic [3:0] be,
                         output logic [31:0] rd);
    int n;
    @(negedge clk);
    req_valid[g] = 1'b1; req_we[g] = we; req_addr[g] = a;
    req_wdata[g] = d; req_be[g] = be;
    while (!req_ready[g]) @(negedge clk);
    @(negedge clk);
    req_valid[g] = 1'b0;
    n = 0;
    while (!rsp_valid[g] && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(rsp_valid[g], "R12 response arrives", 32'(rsp_valid[g]), 32'd1);
    rd = rsp_rdata[g];
    @(negedge clk);
  endtask

  task automatic do_flush(input int g, output bit pulse_ok);
    int n;
    @(negedge clk);
    while (!req_ready[g]) @(negedge clk);
    flush_go[g] = 1'b1;
    @(negedge clk);
    flush_go[g] = 1'b0;
    n = 0;
    while (!flush_done[g] && n < 2000) begin
      @(negedge clk);
      n++;
    end
    pulse_ok = flush_done[g];
    @(negedge clk);
    pulse_ok = pulse_ok && !flush_done[g];
    @(negedge clk);
  endtask

  typedef struct packed {
    int            g;
    bit            we;
    logic [AW-1:0] a;
    logic [31:0]   d;
    logic [3:0]    be;
    logic [31:0]   exp;
    int            rd;
    int            wr;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{0, 1'b0, 12'h024, 32'h0,         4'h0, 32'h5A00_0009, 8, 0}, // R2 miss
    '{0, 1'b0, 12'h028, 32'h0,         4'h0, 32'h5A00_000A, 0, 0}, // R3 hit
    '{0, 1'b1, 12'h024, 32'h1122_3344, 4'hF, 32'h0,         0, 0}, // R6 store hit
    '{0, 1'b0, 12'h024, 32'h0,         4'h0, 32'h1122_3344, 0, 0}, // R6 merged
    '{0, 1'b1, 12'h040, 32'hAABB_CCDD, 4'h3, 32'h0,         8, 0}, // R7 allocate
    '{0, 1'b0, 12'h040, 32'h0,         4'h0, 32'h5A00_CCDD, 0, 0}, // R7 merged
    '{1, 1'b0, 12'h024, 32'h0,         4'h0, 32'h5A00_0009, 8, 0}, // R2 WT miss
    '{1, 1'b1, 12'h024, 32'h0BAD_F00D, 4'hF, 32'h0,         0, 1}, // R4 forwarded
    '{1, 1'b0, 12'h024, 32'h0,         4'h0, 32'h0BAD_F00D, 0, 0}, // R5 updated
    '{1, 1'b1, 12'h300, 32'h1234_5678, 4'hF, 32'h0,         0, 1}, // R4 no allocate
    '{1, 1'b0, 12'h300, 32'h0,         4'h0, 32'h1234_5678, 8, 0}, // R4 miss after
    '{2, 1'b0, 12'h024, 32'h0,         4'h0, 32'h5A00_0009, 8, 0}, // R2
    '{2, 1'b1, 12'h024, 32'hCAFE_BABE, 4'hC, 32'h0,         0, 1}, // R4
    '{2, 1'b0, 12'h024, 32'h0,         4'h0, 32'hCAFE_0009, 8, 0}  // R5 invalidated
  };

  function automatic string vtag(input int i);
    case (i)
      0, 6, 11: return "R2";
      1:        return "R3";
      2, 3:     return "R6";
      4, 5:     return "R7";
      7, 9, 10, 12: return "R4";
      default:  return "R5";
    endcase
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    int r0, w0, base;
    bit ok;
    cyc = 0;
    for (int g = 0; g < NDUT; g++) begin
      req_valid[g] = 0; req_we[g] = 0; req_addr[g] = '0;
      req_wdata[g] = '0; req_be[g] = '0; flush_go[g] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int g = 0; g < NDUT; g++) begin
      check(req_ready[g] && !rsp_valid[g] && !mem_valid[g] && !flush_done[g],
            "R1 idle after reset", {req_ready[g], rsp_valid[g], mem_valid[g], flush_done[g]},
            32'h8);
    end

    // vector table
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      r0 = rd_cnt[v.g]; w0 = wr_cnt[v.g]; base = log_cnt[v.g];
      core_op(v.g, v.we, v.a, v.d, v.be, rd);
      if (!v.we) check(rd == v.exp, vtag(i), rd, v.exp);
      check(rd_cnt[v.g] - r0 == v.rd, vtag(i), 32'(rd_cnt[v.g] - r0), 32'(v.rd));
      check(wr_cnt[v.g] - w0 == v.wr, vtag(i), 32'(wr_cnt[v.g] - w0), 32'(v.wr));
      if (i == 0) begin
        // R2 ascending addresses from line base
        check(log_addr[0][base % LOGN] == 12'h020, "R2 first beat", 32'(log_addr[0][base % LOGN]), 32'h020);
        check(log_addr[0][(base + 7) % LOGN] == 12'h03C, "R2 last beat", 32'(log_addr[0][(base + 7) % LOGN]), 32'h03C);
      end
      if (i == 9) check(mem[1][12'h300 >> 2] == 32'h1234_5678, "R4 data in memory",
                        mem[1][12'h300 >> 2], 32'h1234_5678);
    end

    // R8 dirty eviction: idx1 holds tag0 dirty, load tag1 into it
    base = log_cnt[0];
    core_op(0, 1'b0, 12'h124, 32'h0, 4'h0, rd);
    check(rd == 32'h5A00_0049, "R8 load after eviction", rd, 32'h5A00_0049);
    check(log_we[0][base % LOGN] && log_addr[0][base % LOGN] == 12'h020,
          "R8 first write-back beat", 32'(log_addr[0][base % LOGN]), 32'h020);
    check(log_we[0][(base + 7) % LOGN] && log_addr[0][(base + 7) % LOGN] == 12'h03C,
          "R8 last write-back beat", 32'(log_addr[0][(base + 7) % LOGN]), 32'h03C);
    check(!log_we[0][(base + 8) % LOGN] && log_addr[0][(base + 8) % LOGN] == 12'h120,
          "R8 refill after write-back", 32'(log_addr[0][(base + 8) % LOGN]), 32'h120);
    check(mem[0][9] == 32'h1122_3344, "R8 dirty data reached memory", mem[0][9], 32'h1122_3344);

    // make idx3 and idx5 dirty, idx2 is already dirty
    core_op(0, 1'b1, 12'h060, 32'h3333_3333, 4'hF, rd);
    core_op(0, 1'b1, 12'h0A0, 32'h5555_5555, 4'hF, rd);

    // R10 flush order and pulse
    base = log_cnt[0]; w0 = wr_cnt[0];
    do_flush(0, ok);
    check(ok, "R10 done is one-cycle pulse", 32'(ok), 32'd1);
    check(wr_cnt[0] - w0 == 24, "R10 only dirty lines written", 32'(wr_cnt[0] - w0), 32'd24);
    check(log_addr[0][base % LOGN] == 12'h040, "R10 index 2 first", 32'(log_addr[0][base % LOGN]), 32'h040);
    check(log_addr[0][(base + 8) % LOGN] == 12'h060, "R10 index 3 second", 32'(log_addr[0][(base + 8) % LOGN]), 32'h060);
    check(log_addr[0][(base + 16) % LOGN] == 12'h0A0, "R10 index 5 third", 32'(log_addr[0][(base + 16) % LOGN]), 32'h0A0);

    // R11 memory equals cache for every valid line, R9 lines still valid
    check(mem[0][12'h040 >> 2] == 32'h5A00_CCDD, "R11 idx2 in memory", mem[0][12'h040 >> 2], 32'h5A00_CCDD);
    check(mem[0][12'h060 >> 2] == 32'h3333_3333, "R11 idx3 in memory", mem[0][12'h060 >> 2], 32'h3333_3333);
    check(mem[0][12'h0A0 >> 2] == 32'h5555_5555, "R11 idx5 in memory", mem[0][12'h0A0 >> 2], 32'h5555_5555);
    begin
      logic [AW-1:0] probe [4] = '{12'h040, 12'h060, 12'h0A0, 12'h124};
      for (int k = 0; k < 4; k++) begin
        r0 = rd_cnt[0];
        core_op(0, 1'b0, probe[k], 32'h0, 4'h0, rd);
        check(rd == mem[0][probe[k] >> 2], "R11 cache equals memory", rd, mem[0][probe[k] >> 2]);
        check(rd_cnt[0] == r0, "R9 line still valid after write-back", 32'(rd_cnt[0] - r0), 32'd0);
      end
    end

    // R9 second flush writes nothing
    w0 = wr_cnt[0];
    do_flush(0, ok);
    check(ok && wr_cnt[0] == w0, "R9 clean after write-back", 32'(wr_cnt[0] - w0), 32'd0);

    // R10 write-through flush makes no beats
    w0 = wr_cnt[1]; r0 = rd_cnt[1];
    do_flush(1, ok);
    check(ok && wr_cnt[1] == w0 && rd_cnt[1] == r0, "R10 write-through flush idle",
          32'(wr_cnt[1] - w0), 32'd0);

    // R12 flush_go holds off the request port
    @(negedge clk);
    flush_go[2] = 1'b1;
    #1;
    check(!req_ready[2], "R12 ready low under flush_go", 32'(req_ready[2]), 32'd0);
    flush_go[2] = 1'b0;
    #1;
    check(req_ready[2], "R12 ready back when idle", 32'(req_ready[2]), 32'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule